// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh

This block pairs a word-level memory controller with a behavioural model of a small dynamic memory. The memory cells form a square grid of multi-bit supercells. They are reached only through a narrow address bus that is shared in time. A row strobe latches a row index and copies the whole row into an internal row buffer. A column strobe then picks one supercell out of that buffer. Several identical storage slices sit side by side and together make up one wide host word. Every slice sees the same row and column index and supplies its own byte lane.

The host issues single-word reads and writes over a valid/ready port. The controller keeps the most recently opened row live. A later access to that same row costs only a column strobe. An access to a different row first closes the live row with a precharge, then opens the new one. A free-running interval timer asks for refresh. When a refresh is due, the controller stops taking host requests. It closes any live row and sweeps a row strobe over every row in ascending order. It then resumes with no row open. Each response says whether the access was served from the already-open row.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is applied and right after it, `req_ready` is 1 and `resp_valid`, `dram_ras`, `dram_cas` and `dram_pre` are 0.
- R2: A read returns the word most recently written to the same host address. The host address is `{row, column}`, with the row index in the upper `ROW_W` bits.
- R3: On the shared address pins, the row index is present in every cycle with `dram_ras` high during host service. The column index is present in every cycle with `dram_cas` high.
- R4: When an accepted request targets the open row, it causes no row strobe and no precharge. `resp_valid` rises 2 cycles after the accepting clock edge's preceding sample, and `resp_hit` is 1.
- R5: When no row is open, a request causes exactly one row strobe, no precharge and then one column strobe. The response comes one cycle later than a hit, with `resp_hit` 0.
- R6: When a different row is open, a request causes one precharge, one row strobe and one column strobe, in that order. The response comes two cycles later than a hit, with `resp_hit` 0.
- R7: A write to the open row is kept in the storage grid as well as the row buffer. After another row has been opened, reading the written address returns the new value.
- R8: A refresh sweep starts no more than `REFRESH_CYCLES` plus a small fixed slack of cycles after reset release or after the previous sweep.
- R9: A refresh sweep is `ROWS` consecutive row strobes with indices 0 up to `ROWS-1`. `req_ready` stays low during the sweep. Afterwards no row is open, so the next access is a miss with no precharge.
- R10: A due refresh takes priority over a waiting host request. The waiting request is accepted once the sweep is over, so its wait is bounded.
- R11: Each accepted request yields exactly one column strobe and exactly one response, one cycle after that strobe. `req_ready` is 0 in every cycle in which any strobe or precharge is driven.
- R12: The host word is `CHIPS` byte lanes wide. Slice k stores bits `8k+7` down to `8k` of every word, and both lanes of a read match what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row index in the upper bits |
| req_wdata | input | DATA_W*CHIPS | Write data |
| resp_valid | output | 1 | One-cycle response pulse for each accepted request |
| resp_hit | output | 1 | The access was served from the already-open row |
| resp_rdata | output | DATA_W*CHIPS | Read data, meaningful with resp_valid on reads |
| dram_ras | output | 1 | Row strobe toward the storage slices |
| dram_cas | output | 1 | Column strobe toward the storage slices |
| dram_pre | output | 1 | Precharge (close row) toward the storage slices |
| dram_we | output | 1 | Write enable qualifying the column strobe |
| dram_addr | output | PIN_W | Time-shared row/column index |

## Verification
Suppose the controller loses track of which row is open. The fault shows on the very next request, in two ways. The response carries the wrong hit flag. The strobe count before the column access is also wrong, with a row strobe missing or a stray one present. A broken write-through path stays hidden while the row is open. It appears only when that address is read after a different row has been opened, so the bench walks rows in column-major order after writing. A stuck refresh timer or a wrong sweep order shows up within one refresh interval as a late sweep, a short burst or out-of-order row indices.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ACT  = 3'd2,
    ST_COL  = 3'd3,
    ST_REF  = 3'd4
  } dpc_state_e;

endpackage

// File: rtl/dpc_refresh_timer.sv
module dpc_refresh_timer #(
  parameter int INTERVAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign tick = (cnt_q == CNT_W'(INTERVAL - 1));

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dpc_sequencer.sv
module dpc_sequencer
  import dpc_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int WORD_W = 16,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int PIN_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   refresh_tick,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [WORD_W-1:0]      req_wdata,
  output logic                   resp_valid,
  output logic                   resp_hit,
  output logic                   pin_ras,
  output logic                   pin_cas,
  output logic                   pin_pre,
  output logic                   pin_we,
  output logic [PIN_W-1:0]       pin_addr,
  output logic [WORD_W-1:0]      pin_wdata,
  output logic                   refreshing
);

  // control state (reset)
  dpc_state_e state_q, state_d;
  logic       open_q, open_d;
  logic       pend_q, pend_d;
  logic       refgo_q, refgo_d;
  logic       resp_valid_q, resp_valid_d;

  // datapath state (no reset, explicit enables)
  logic              wr_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [WORD_W-1:0] data_q;
  logic              hit_q;
  logic [ROW_W-1:0]  orow_q;
  logic [ROW_W-1:0]  rrow_q;
  logic              resp_hit_q;

  logic             cap_en, orow_en, rrow_clr, rrow_inc, hit_now;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [PIN_W-1:0] row_pin, col_pin, ref_pin;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];
  assign hit_now = open_q && (req_row == orow_q);

  always_comb begin
    state_d      = state_q;
    open_d       = open_q;
    pend_d       = pend_q | refresh_tick;
    refgo_d      = refgo_q;
    resp_valid_d = 1'b0;
    cap_en       = 1'b0;
    orow_en      = 1'b0;
    rrow_clr     = 1'b0;
    rrow_inc     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pend_q) begin
          pend_d   = refresh_tick;
          rrow_clr = 1'b1;
          if (open_q) begin
            state_d = ST_PRE;
            refgo_d = 1'b1;
          end else begin
            state_d = ST_REF;
          end
        end else if (req_valid) begin
          cap_en  = 1'b1;
          refgo_d = 1'b0;
          if (hit_now)     state_d = ST_COL;
          else if (open_q) state_d = ST_PRE;
          else             state_d = ST_ACT;
        end
      end
      ST_PRE: begin
        open_d  = 1'b0;
        state_d = refgo_q ? ST_REF : ST_ACT;
      end
      ST_ACT: begin
        open_d  = 1'b1;
        orow_en = 1'b1;
        state_d = ST_COL;
      end
      ST_COL: begin
        resp_valid_d = 1'b1;
        state_d      = ST_IDLE;
      end
      ST_REF: begin
        rrow_inc = 1'b1;
        if (rrow_q == ROW_W'(ROWS - 1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      open_q       <= 1'b0;
      pend_q       <= 1'b0;
      refgo_q      <= 1'b0;
      resp_valid_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      open_q       <= open_d;
      pend_q       <= pend_d;
      refgo_q      <= refgo_d;
      resp_valid_q <= resp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      wr_q   <= req_write;
      row_q  <= req_row;
      col_q  <= req_col;
      data_q <= req_wdata;
      hit_q  <= hit_now;
    end
    if (orow_en) orow_q <= row_q;
    if (rrow_clr)      rrow_q <= '0;
    else if (rrow_inc) rrow_q <= rrow_q + 1'b1;
    if (state_q == ST_COL) resp_hit_q <= hit_q;
  end

  always_comb begin
    row_pin = '0;
    col_pin = '0;
    ref_pin = '0;
    row_pin[ROW_W-1:0] = row_q;
    col_pin[COL_W-1:0] = col_q;
    ref_pin[ROW_W-1:0] = rrow_q;
  end

  always_comb begin
    case (state_q)
      ST_ACT:  pin_addr = row_pin;
      ST_COL:  pin_addr = col_pin;
      ST_REF:  pin_addr = ref_pin;
      default: pin_addr = '0;
    endcase
  end

  assign req_ready  = (state_q == ST_IDLE) && !pend_q;
  assign pin_ras    = (state_q == ST_ACT) || (state_q == ST_REF);
  assign pin_cas    = (state_q == ST_COL);
  assign pin_pre    = (state_q == ST_PRE);
  assign pin_we     = (state_q == ST_COL) && wr_q;
  assign pin_wdata  = data_q;
  assign refreshing = (state_q == ST_REF);
  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;

endmodule

// File: rtl/dpc_cell_array.sv
module dpc_cell_array #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int PIN_W  = 2
) (
  input  logic              clk,
  input  logic              ras,
  input  logic              cas,
  input  logic              pre,
  input  logic              we,
  input  logic [PIN_W-1:0]  addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] grid    [ROWS][COLS];
  logic [DATA_W-1:0] row_buf [COLS];
  logic [ROW_W-1:0]  cur_row;
  logic              row_live;
  logic [ROW_W-1:0]  a_row;
  logic [COL_W-1:0]  a_col;

  assign a_row = addr[ROW_W-1:0];
  assign a_col = addr[COL_W-1:0];

  // row strobe: whole row into the buffer
  always_ff @(posedge clk) begin
    if (ras) begin
      row_buf  <= grid[a_row];
      cur_row  <= a_row;
      row_live <= 1'b1;
    end else if (pre) begin
      row_live <= 1'b0;
    end
    if (cas && row_live && we) row_buf[a_col] <= din;
  end

  // write-through into the grid and column read out of the buffer
  always_ff @(posedge clk) begin
    if (cas && row_live && we)  grid[cur_row][a_col] <= din;
    if (cas && row_live && !we) dout <= row_buf[a_col];
  end

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ROWS           = 4,
  parameter int COLS           = 4,
  parameter int DATA_W         = 8,
  parameter int CHIPS          = 2,
  parameter int REFRESH_CYCLES = 64,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int HA_W   = ROW_W + COL_W,
  localparam int WORD_W = DATA_W * CHIPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [HA_W-1:0]   req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WORD_W-1:0] resp_rdata,
  output logic              dram_ras,
  output logic              dram_cas,
  output logic              dram_pre,
  output logic              dram_we,
  output logic [PIN_W-1:0]  dram_addr
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              refresh_tick;
  logic              refreshing;
  logic [WORD_W-1:0] pin_wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dpc_refresh_timer #(.INTERVAL(REFRESH_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n_s),
    .tick (refresh_tick)
  );

  dpc_sequencer #(
    .ROWS  (ROWS),
    .WORD_W(WORD_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .PIN_W (PIN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .refresh_tick(refresh_tick),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .pin_ras     (dram_ras),
    .pin_cas     (dram_cas),
    .pin_pre     (dram_pre),
    .pin_we      (dram_we),
    .pin_addr    (dram_addr),
    .pin_wdata   (pin_wdata),
    .refreshing  (refreshing)
  );

  // one storage slice per byte lane, all sharing strobes and index
  for (genvar k = 0; k < CHIPS; k++) begin : g_slice
    dpc_cell_array #(
      .ROWS  (ROWS),
      .COLS  (COLS),
      .DATA_W(DATA_W),
      .ROW_W (ROW_W),
      .COL_W (COL_W),
      .PIN_W (PIN_W)
    ) u_slice (
      .clk (clk),
      .ras (dram_ras),
      .cas (dram_cas),
      .pre (dram_pre),
      .we  (dram_we),
      .addr(dram_addr),
      .din (pin_wdata[k*DATA_W +: DATA_W]),
      .dout(resp_rdata[k*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int REFRESH_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_hit,
  input logic dram_ras,
  input logic dram_cas,
  input logic dram_pre,
  input logic refreshing
);

  localparam int GAP_MAX = REFRESH_CYCLES + 8;
  localparam int GW      = $clog2(GAP_MAX + 4) + 1;

  logic [GW-1:0] gap_q;
  logic          ref_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= '0;
      ref_prev_q <= 1'b0;
    end else begin
      ref_prev_q <= refreshing;
      if (refreshing && !ref_prev_q) gap_q <= '0;
      else if (gap_q != {GW{1'b1}})  gap_q <= gap_q + 1'b1;
    end
  end

  // R3: strobes never overlap
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dram_ras, dram_cas, dram_pre}));

  // R4: a hit response had no row strobe or precharge before its column strobe
  a_r4_hit_no_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> (!$past(dram_ras, 2) && !$past(dram_pre, 2)));

  // R5: a miss response had a row strobe right before its column strobe
  a_r5_miss_has_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> $past(dram_ras, 2));

  // R11: column strobe is followed by a response and every response follows one
  a_r11_cas_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
    dram_cas |=> resp_valid);

  a_r11_resp_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(dram_cas));

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras || dram_cas || dram_pre) |-> !req_ready);

  // R9: host is held off during a refresh sweep
  a_r9_ready_low_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    refreshing |-> !req_ready);

  // R8: sweeps recur within the interval plus slack
  a_r8_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GW'(GAP_MAX));

endmodule

bind dram_page_ctrl dpc_checker #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_dpc_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .req_ready (req_ready),
  .resp_valid(resp_valid),
  .resp_hit  (resp_hit),
  .dram_ras  (dram_ras),
  .dram_cas  (dram_cas),
  .dram_pre  (dram_pre),
  .refreshing(refreshing)
);

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 4;
  localparam int COLS       = 4;
  localparam int DATA_W     = 8;
  localparam int CHIPS      = 2;
  localparam int REF_CYC    = 60;
  localparam int WORD_W     = DATA_W * CHIPS;
  localparam int NADDR      = ROWS * COLS;
  localparam int GAP_LIM    = REF_CYC + 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [3:0]        req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic              resp_valid;
  logic              resp_hit;
  logic [WORD_W-1:0] resp_rdata;
  logic              dram_ras, dram_cas, dram_pre, dram_we;
  logic [1:0]        dram_addr;

  dram_page_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .CHIPS(CHIPS), .REFRESH_CYCLES(REF_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_pre(dram_pre),
    .dram_we(dram_we), .dram_addr(dram_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  // reference model state
  logic [WORD_W-1:0] mdl [NADDR];
  bit          outstanding = 0, opened = 0, in_ref = 0, waiting = 0;
  bit          exp_hit, exp_rd, last_hit;
  logic [WORD_W-1:0] exp_data, last_rdata;
  logic [1:0]  exp_row, exp_col, open_row;
  int          due, exp_ras, exp_pre, ras_cnt, pre_cnt, cas_cnt;
  int          ref_idx = 0, last_ref_start = 0, ref_starts = 0, ref_while_wait = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle_step(input bit want, input bit wr, input logic [3:0] a,
                            input logic [WORD_W-1:0] d, output bit took);
    string lt;
    @(negedge clk);
    cyc++;
    // response side
    if (outstanding && cyc == due) begin
      lt = exp_hit ? "R4" : ((exp_pre != 0) ? "R6" : "R5");
      chk(resp_valid === 1'b1, "R11 response on time", 32'(resp_valid), 1);
      chk(resp_hit === exp_hit, {lt, " hit flag"}, 32'(resp_hit), 32'(exp_hit));
      chk(ras_cnt == exp_ras, {lt, " row strobe count"}, ras_cnt, exp_ras);
      chk(pre_cnt == exp_pre, {lt, " precharge count"}, pre_cnt, exp_pre);
      chk(cas_cnt == 1, "R11 one column strobe", cas_cnt, 1);
      if (exp_rd) begin
        chk(resp_rdata === exp_data, "R2 R12 read word", resp_rdata, exp_data);
        last_rdata = resp_rdata;
      end
      last_hit = resp_hit;
      outstanding = 0;
    end else begin
      chk(resp_valid === 1'b0, "R11 no stray response", 32'(resp_valid), 0);
    end
    // pin side
    if (dram_ras || dram_cas || dram_pre)
      chk(req_ready === 1'b0, "R11 ready low while busy", 32'(req_ready), 0);
    if (dram_ras) begin
      if (outstanding) begin
        ras_cnt++;
        chk(dram_addr === exp_row, "R3 row index on RAS", dram_addr, exp_row);
      end else begin
        if (!in_ref) begin
          chk(cyc - last_ref_start <= GAP_LIM, "R8 refresh gap", cyc - last_ref_start, GAP_LIM);
          last_ref_start = cyc;
          ref_starts++;
          ref_idx = 0;
          opened = 0;
          in_ref = 1;
          if (waiting) ref_while_wait++;
        end
        chk(dram_addr === 2'(ref_idx), "R9 refresh row order", dram_addr, ref_idx);
        chk(req_ready === 1'b0, "R9 ready low in sweep", 32'(req_ready), 0);
        ref_idx++;
      end
    end else if (in_ref) begin
      chk(ref_idx == ROWS, "R9 sweep length", ref_idx, ROWS);
      in_ref = 0;
    end
    if (dram_cas) begin
      cas_cnt++;
      chk(outstanding && dram_addr === exp_col, "R3 column index on CAS", dram_addr, exp_col);
    end
    if (dram_pre && outstanding) pre_cnt++;
    // drive
    req_valid = want;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    #1;
    took = want && req_ready;
    waiting = want && !took;
    if (took) begin
      exp_row = a[3:2];
      exp_col = a[1:0];
      exp_hit = opened && (exp_row == open_row);
      exp_pre = (opened && !exp_hit) ? 1 : 0;
      exp_ras = exp_hit ? 0 : 1;
      due     = cyc + (exp_hit ? 2 : (opened ? 4 : 3));
      exp_rd  = !wr;
      exp_data = mdl[a];
      if (wr) mdl[a] = d;
      opened = 1;
      open_row = exp_row;
      outstanding = 1;
      ras_cnt = 0;
      pre_cnt = 0;
      cas_cnt = 0;
    end
  endtask

  task automatic issue(input bit wr, input logic [3:0] a, input logic [WORD_W-1:0] d);
    bit took = 0;
    int waits = 0;
    while (!took) begin
      cycle_step(1'b1, wr, a, d, took);
      if (!took) waits++;
    end
    chk(waits <= ROWS + 8, "R10 host wait bounded", waits, ROWS + 8);
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) cycle_step(1'b0, 1'b0, 4'h0, '0, t);
  endtask

  task automatic drain();
    bit t;
    while (outstanding) cycle_step(1'b0, 1'b0, 4'h0, '0, t);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    logic [3:0] ra;
    #2 rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_ready === 1'b1, "R1 ready in reset", 32'(req_ready), 1);
      chk(resp_valid === 1'b0, "R1 no response in reset", 32'(resp_valid), 0);
      chk({dram_ras, dram_cas, dram_pre} === 3'b000, "R1 no strobes in reset",
          32'({dram_ras, dram_cas, dram_pre}), 0);
    end
    rst_n = 1'b1;
    last_ref_start = cyc;
    idle(3);
    chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);

    // fill row-major: first access per row misses, rest hit (R4, R5, R6)
    for (int i = 0; i < NADDR; i++)
      issue(1'b1, 4'(i), {8'(8'h30 + i), 8'(8'hC0 ^ (i * 7))});
    // read back row-major (R2, R4)
    for (int i = 0; i < NADDR; i++) issue(1'b0, 4'(i), '0);
    // column-major: every access changes row (R6)
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) issue(1'b0, {2'(r), 2'(c)}, '0);
    drain();

    // R7: write-through survives a row change
    issue(1'b1, {2'd2, 2'd1}, 16'hA55A);
    issue(1'b0, {2'd0, 2'd0}, '0);
    issue(1'b0, {2'd2, 2'd1}, '0);
    drain();
    chk(last_rdata === 16'hA55A, "R7 write kept after row change", last_rdata, 16'hA55A);

    // R12: distinct byte lanes
    issue(1'b1, {2'd3, 2'd2}, 16'hC35A);
    issue(1'b0, {2'd1, 2'd0}, '0);
    issue(1'b0, {2'd3, 2'd2}, '0);
    drain();
    chk(last_rdata[15:8] === 8'hC3, "R12 upper lane", last_rdata[15:8], 8'hC3);
    chk(last_rdata[7:0] === 8'h5A, "R12 lower lane", last_rdata[7:0], 8'h5A);

    // R9: refresh closes the open row
    issue(1'b0, {2'd1, 2'd3}, '0);
    drain();
    idle(REF_CYC + 12);
    issue(1'b0, {2'd1, 2'd2}, '0);
    drain();
    chk(last_hit == 1'b0, "R9 row closed after refresh", 32'(last_hit), 0);

    // continuous mixed traffic (R2, R8, R10)
    for (int i = 0; i < 500; i++) begin
      ra = 4'($urandom_range(0, NADDR - 1));
      if (($urandom_range(0, 3)) == 0) issue(1'b1, ra, 16'($urandom));
      else if ((i % 3) == 0)           issue(1'b0, {ra[3:2], 2'(ra[1:0] + 1)}, '0);
      else                             issue(1'b0, ra, '0);
    end
    drain();
    idle(2);

    chk(ref_starts > 0, "R8 refresh occurred", ref_starts, 1);
    chk(cyc - last_ref_start <= GAP_LIM, "R8 final gap", cyc - last_ref_start, GAP_LIM);
    chk(ref_while_wait > 0, "R10 refresh ran ahead of a waiting request", ref_while_wait, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      done = 1;
      summary();
      $finish;
    end
  end

endmodule